// File: doc/BRIEF.md
# NACK Backoff Retry Controller

This block drains an internal request queue onto a memory-side request channel. The channel can turn a request away in two ways. It can hold ready low in the issue cycle, and the controller then waits for a retry pulse before it offers the same head entry again. It can also accept the request and later return it with a negative-acknowledge flag set. In that case the controller pushes the returned request back onto the front of its queue and stays quiet for a backoff interval before it sends anything.

The backoff interval adapts to how the channel behaves. Each NACK raises it to a floor, or doubles it up to a ceiling. Each clean response quarters it by shifting it right two places. While the interval is zero, queued requests go out back to back. While it is nonzero, each issue attempt sends a single request and then starts a down-counter that gates the next attempt.

Occupancy counts queued entries plus requests that are issued but not yet answered. This guarantees that a NACKed request always has a free slot to return to.

Top module: `nack_backoff_ctl`

## Requirements
- R1: Requests leave in the order they were accepted. `req_valid` is high whenever the queue is non-empty, no retry wait is pending and the backoff timer is at zero. With a zero backoff value, one request is issued per cycle.
- R2: A cycle with `req_valid` high and `req_ready` low starts a retry wait. `req_valid` stays low until a `retry` pulse has been seen, and the same head entry is offered next. A `retry` pulse with no wait pending has no effect.
- R3: On a NACK (`rsp_valid` and `rsp_nack` high), a backoff value below `MIN_BO` becomes `MIN_BO`.
- R4: On a NACK, a backoff value at or above `MIN_BO` and below `MAX_BO` doubles (saturating at the register width). A value at or above `MAX_BO` is kept.
- R5: A response without NACK shifts the backoff value right by two bits.
- R6: A NACKed request, carried on `rsp_data`, becomes the new queue head. It goes out ahead of every queued entry, including one accepted in the same cycle, and also when it arrives in the same cycle as an issue.
- R7: A NACK loads the timer with the updated backoff value B. `req_valid` is then low for exactly B cycles and may rise in the cycle after.
- R8: An issue in a cycle whose updated backoff value B is nonzero, and after which the queue still holds entries, loads the timer with B. The next request is then offered only after B idle cycles.
- R9: `in_ready` is low exactly when queued entries plus outstanding requests equal `DEPTH`.
- R10: Reset empties the queue and clears the backoff value, the retry wait and the timer. After reset, `req_valid` is low and `in_ready` is high, and the first requests issue back to back with no retry pulse needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | New request offered to the queue |
| in_ready | output | 1 | Queue can take a request this cycle |
| in_data | input | DW | New request payload |
| req_valid | output | 1 | Head request offered to the channel |
| req_ready | input | 1 | Channel takes the offered request |
| req_data | output | DW | Head request payload |
| retry | input | 1 | One-cycle pulse: channel can accept again |
| rsp_valid | input | 1 | Response for an issued request |
| rsp_nack | input | 1 | Response is a negative acknowledge |
| rsp_data | input | DW | Request payload returned with a NACK |

## Verification
A NACK can land in the same cycle as an enqueue, and also in the same cycle as an issue. In both cases the queue is written at both ends, or popped and pushed at the head, in one edge. The vector walk raises a NACK while a new entry is being accepted. It then requires the NACKed payload to come out first, after exactly the doubled backoff, and the new entry to follow one backoff later. A directed sequence after reset raises a NACK in the cycle the next request issues. It then checks that the returned payload reappears at the head after a gap equal to the floor value.

// File: rtl/nack_backoff_ctl.sv
module nack_backoff_ctl #(
  parameter int DW     = 16,
  parameter int DEPTH  = 4,
  parameter int BW     = 8,
  parameter int MIN_BO = 4,
  parameter int MAX_BO = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_data,
  output logic          req_valid,
  input  logic          req_ready,
  output logic [DW-1:0] req_data,
  input  logic          retry,
  input  logic          rsp_valid,
  input  logic          rsp_nack,
  input  logic [DW-1:0] rsp_data
);

  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [BW-1:0] BO_LO = BW'(MIN_BO);
  localparam logic [BW-1:0] BO_HI = BW'(MAX_BO);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] hd_q, tl_q;
  logic [CW-1:0] cnt_q, pend_q, cnt_nxt, pend_nxt;
  logic [BW-1:0] bo_q, bo_nxt, tmr_q;
  logic          wait_q;
  logic          fire, refuse, push, nack, ok;

  function automatic logic [AW-1:0] p_inc(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  function automatic logic [AW-1:0] p_dec(input logic [AW-1:0] p);
    return (p == '0) ? AW'(DEPTH - 1) : p - 1'b1;
  endfunction

  assign req_valid = (cnt_q != '0) && !wait_q && (tmr_q == '0);
  assign req_data  = mem[hd_q];
  assign in_ready  = (int'(cnt_q) + int'(pend_q)) < DEPTH;

  assign fire   = req_valid && req_ready;
  assign refuse = req_valid && !req_ready;
  assign push   = in_valid && in_ready;
  assign nack   = rsp_valid && rsp_nack;
  assign ok     = rsp_valid && !rsp_nack;

  assign cnt_nxt  = cnt_q + CW'(push) + CW'(nack) - CW'(fire);
  assign pend_nxt = pend_q + CW'(fire) - CW'(rsp_valid);

  always_comb begin
    bo_nxt = bo_q;
    if (nack) begin
      if (bo_q < BO_LO)
        bo_nxt = BO_LO;
      else if (bo_q < BO_HI)
        bo_nxt = bo_q[BW-1] ? '1 : {bo_q[BW-2:0], 1'b0};
    end else if (ok) begin
      bo_nxt = bo_q >> 2;
    end
  end

  always_ff @(posedge clk) begin
    if (nack) begin
      if (fire) mem[hd_q] <= rsp_data;
      else      mem[p_dec(hd_q)] <= rsp_data;
    end
    if (push) mem[tl_q] <= in_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hd_q   <= '0;
      tl_q   <= '0;
      cnt_q  <= '0;
      pend_q <= '0;
      bo_q   <= '0;
      tmr_q  <= '0;
      wait_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_nxt;
      pend_q <= pend_nxt;
      bo_q   <= bo_nxt;
      if (push) tl_q <= p_inc(tl_q);
      if (nack && !fire)
        hd_q <= p_dec(hd_q);
      else if (fire && !nack)
        hd_q <= p_inc(hd_q);
      if (refuse)
        wait_q <= 1'b1;
      else if (retry)
        wait_q <= 1'b0;
      if (nack)
        tmr_q <= bo_nxt;
      else if (fire && bo_nxt != '0 && cnt_nxt != '0)
        tmr_q <= bo_nxt;
      else if (tmr_q != '0)
        tmr_q <= tmr_q - 1'b1;
    end
  end

endmodule

// File: rtl/nack_backoff_ctl_chk.sv
module nack_backoff_ctl_chk #(
  parameter int DEPTH  = 4,
  parameter int BW     = 8,
  parameter int MIN_BO = 4,
  parameter int MAX_BO = 64,
  parameter int CW     = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_ready,
  input logic          rsp_valid,
  input logic          rsp_nack,
  input logic [BW-1:0] bo,
  input logic [CW-1:0] qcnt,
  input logic [CW-1:0] pend
);

  p_refuse_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> !req_valid);

  p_bo_floor_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_nack |=> int'(bo) >= MIN_BO);

  p_bo_cap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_nack && int'(bo) >= MAX_BO |=> $stable(bo));

  p_bo_decay_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_nack |=> bo == ($past(bo) >> 2));

  p_nack_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_nack |=> !req_valid);

  p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(qcnt) + int'(pend)) <= DEPTH);

endmodule

bind nack_backoff_ctl nack_backoff_ctl_chk #(
  .DEPTH(DEPTH), .BW(BW), .MIN_BO(MIN_BO), .MAX_BO(MAX_BO), .CW(CW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .rsp_valid(rsp_valid), .rsp_nack(rsp_nack), .bo(bo_q), .qcnt(cnt_q),
  .pend(pend_q)
);

// File: tb/nack_backoff_ctl_bench.sv
module nack_backoff_ctl_bench;
  localparam int CLK_P = 10;
  localparam int DW = 8, DEPTH = 4, BW = 6, MIN_BO = 2, MAX_BO = 8;
  localparam int WD = 5000;

  typedef struct packed {
    logic [7:0] rep;
    logic       iv;
    logic [7:0] id;
    logic       rdy, rt, rsv, nk;
    logic [7:0] rdat;
    logic       erv;
    logic [7:0] edat;
    logic       eir;
    logic [7:0] tag;
  } row_t;

  function automatic row_t mk(int rep, int iv, int id, int rdy, int rt, int rsv, int nk,
                              int rdat, int erv, int edat, int eir, int tag);
    row_t r;
    r.rep = 8'(rep); r.iv = 1'(iv); r.id = 8'(id); r.rdy = 1'(rdy); r.rt = 1'(rt);
    r.rsv = 1'(rsv); r.nk = 1'(nk); r.rdat = 8'(rdat); r.erv = 1'(erv);
    r.edat = 8'(edat); r.eir = 1'(eir); r.tag = 8'(tag);
    return r;
  endfunction

  // fields: rep, in_valid, in_data, req_ready, retry, rsp_valid, rsp_nack, rsp_data,
  //         exp req_valid, exp req_data, exp in_ready, requirement
  localparam int NA = 39;
  localparam row_t TA [NA] = '{
    mk(1,1,8'h11,1,0,0,0,0,     0,0,1,10),     // R10 state after reset
    mk(1,1,8'h12,1,0,0,0,0,     1,8'h11,1,1),  // R1
    mk(1,1,8'h13,1,1,0,0,0,     1,8'h12,1,2),  // R2 retry with no wait ignored
    mk(1,0,0,0,0,0,0,0,         1,8'h13,1,2),  // R2 refused
    mk(1,0,0,1,0,0,0,0,         0,0,1,2),
    mk(1,0,0,1,1,0,0,0,         0,0,1,2),      // retry pulse
    mk(1,0,0,1,0,0,0,0,         1,8'h13,1,2),  // same head offered again
    mk(1,0,0,1,0,1,0,8'h11,     0,0,1,1),
    mk(1,0,0,1,0,1,1,8'h12,     0,0,1,3),      // R3 0 -> MIN
    mk(2,0,0,1,0,0,0,0,         0,0,1,7),      // R7 gap of 2
    mk(1,0,0,1,0,0,0,0,         1,8'h12,1,6),  // R6
    mk(1,1,8'h14,1,0,1,1,8'h13, 0,0,1,4),      // R4 2 -> 4, NACK with enqueue
    mk(4,0,0,1,0,0,0,0,         0,0,1,4),
    mk(1,0,0,1,0,0,0,0,         1,8'h13,1,6),  // R6 NACKed entry first
    mk(4,0,0,1,0,0,0,0,         0,0,1,8),      // R8 one per attempt
    mk(1,0,0,1,0,0,0,0,         1,8'h14,1,8),
    mk(1,0,0,1,0,1,0,8'h12,     0,0,1,5),      // R5 4 -> 1
    mk(1,1,8'h21,1,0,0,0,0,     0,0,1,5),
    mk(1,1,8'h22,1,0,0,0,0,     1,8'h21,1,8),  // R8 backoff 1
    mk(1,0,0,1,0,0,0,0,         0,0,0,9),      // R9 full
    mk(1,0,0,1,0,0,0,0,         1,8'h22,0,8),
    mk(1,0,0,1,0,1,0,8'h13,     0,0,0,9),      // R5 1 -> 0
    mk(1,0,0,1,0,1,1,8'h31,     0,0,1,9),      // R3 0 -> MIN
    mk(2,0,0,1,0,0,0,0,         0,0,1,3),
    mk(1,0,0,1,0,0,0,0,         1,8'h31,1,7),
    mk(1,0,0,1,0,1,1,8'h31,     0,0,1,4),      // R4 2 -> 4
    mk(4,0,0,1,0,0,0,0,         0,0,1,4),
    mk(1,0,0,1,0,0,0,0,         1,8'h31,1,4),
    mk(1,0,0,1,0,1,1,8'h31,     0,0,1,4),      // R4 4 -> 8
    mk(8,0,0,1,0,0,0,0,         0,0,1,4),
    mk(1,0,0,1,0,0,0,0,         1,8'h31,1,4),
    mk(1,0,0,1,0,1,1,8'h31,     0,0,1,4),      // R4 at MAX kept
    mk(8,0,0,1,0,0,0,0,         0,0,1,4),
    mk(1,0,0,1,0,0,0,0,         1,8'h31,1,4),
    mk(1,0,0,1,0,1,0,8'h14,     0,0,1,5),      // R5 8 -> 2
    mk(1,0,0,1,0,1,1,8'h31,     0,0,1,5),      // R4 2 -> 4
    mk(4,0,0,1,0,0,0,0,         0,0,1,4),
    mk(1,0,0,1,0,0,0,0,         1,8'h31,1,4),
    mk(1,0,0,1,0,0,0,0,         0,0,1,1)
  };

  localparam int NB = 6;
  localparam row_t TB [NB] = '{
    mk(1,1,8'h41,1,0,0,0,0,     0,0,1,10),     // R10 reset cleared all state
    mk(1,1,8'h42,1,0,0,0,0,     1,8'h41,1,10), // R10 no retry needed
    mk(1,0,0,1,0,1,1,8'h41,     1,8'h42,1,6),  // R6 NACK with issue
    mk(2,0,0,1,0,0,0,0,         0,0,1,10),     // R10 backoff restarted at MIN
    mk(1,0,0,1,0,0,0,0,         1,8'h41,1,6),
    mk(1,0,0,1,0,0,0,0,         0,0,1,1)
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, req_ready = 1'b0, retry = 1'b0, rsp_valid = 1'b0, rsp_nack = 1'b0;
  logic [DW-1:0] in_data = '0, rsp_data = '0;
  logic in_ready, req_valid;
  logic [DW-1:0] req_data;
  int checks = 0, errors = 0;

  always #(CLK_P/2) clk = ~clk;

  nack_backoff_ctl #(.DW(DW), .DEPTH(DEPTH), .BW(BW), .MIN_BO(MIN_BO), .MAX_BO(MAX_BO)) u_nack_backoff_ctl (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .req_valid(req_valid), .req_ready(req_ready), .req_data(req_data), .retry(retry),
    .rsp_valid(rsp_valid), .rsp_nack(rsp_nack), .rsp_data(rsp_data)
  );

  task automatic chk(string what, int tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL R%0d %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic drive(row_t r);
    in_valid = r.iv; in_data = r.id; req_ready = r.rdy; retry = r.rt;
    rsp_valid = r.rsv; rsp_nack = r.nk; rsp_data = r.rdat;
  endtask

  task automatic run_row(row_t r);
    for (int k = 0; k < int'(r.rep); k++) begin
      @(negedge clk);
      chk("req_valid", int'(r.tag), int'(req_valid), int'(r.erv));
      if (r.erv) chk("req_data", int'(r.tag), int'(req_data), int'(r.edat));
      chk("in_ready", int'(r.tag), int'(in_ready), int'(r.eir));
      drive(r);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    drive(mk(1,0,0,0,0,0,0,0,0,0,0,0));
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (WD) @(posedge clk);
    errors++;
    $display("FAIL R1 watchdog: actual %0d cycles expected fewer", WD);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    do_reset();
    for (int i = 0; i < NA; i++) run_row(TA[i]);
    // leave a refusal wait, a running timer and a raised backoff behind
    @(negedge clk); drive(mk(1,1,8'h51,0,0,0,0,0,0,0,0,0));
    @(negedge clk); drive(mk(1,0,0,0,0,1,1,8'h31,0,0,0,0));
    do_reset();
    for (int i = 0; i < NB; i++) run_row(TB[i]);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule